// File: doc/BRIEF.md
# Streaming SECDED Word Guard

This block protects 128-bit stream words from the point where they are produced to the point where they are consumed. On the producer side a purely combinational encoder appends nine check bits, forming a 137-bit coded word. That word then passes unchanged through any amount of storage and any number of pipeline registers. On the consumer side a checker recomputes the code before the word is used. It repairs any single flipped bit and refuses any word with two flipped bits.

The checker has one register stage. For every accepted word it presents the repaired data together with a correction flag or a fatal-error flag. A small register set, read through a combinational read port and cleared through a write-one port, keeps three things: a saturating count of repaired words for wear-out tracking, the syndrome of the most recent faulty word, and a sticky fatal flag. The sticky fatal flag drives the interrupt line.

Top module: `sdg_stream_guard`

## Requirements
- R1: The coded word carries Hamming position p (1..136) at bit p, with the check bits at positions 1, 2, 4, 8, 16, 32, 64 and 128. Data bits 0..127 fill the remaining positions in ascending order. Bit 0 makes the total parity of all 137 bits even.
- R2: One clock edge after `cons_valid` is sampled high with an error-free word, `out_valid`=1, `out_data` equals the original data, and `out_fix`=`out_fatal`=0.
- R3: When exactly one of the 137 bits is flipped, including bit 0 or a check bit, the checker returns the original data with `out_valid`=1 and `out_fix`=1.
- R4: When exactly two bits are flipped, the word is refused: `out_valid`=0 and `out_fatal`=1.
- R5: A cycle with `cons_valid`=0 gives `out_valid`=`out_fix`=`out_fatal`=0 on the next cycle and leaves the registers unchanged, whatever `cons_code` holds. After reset all outputs and registers read zero.
- R6: Register address 0 counts repaired words. It updates one edge after the `out_fix` pulse and saturates at 65535.
- R7: Register address 1 holds {parity-mismatch bit at bit 8, Hamming syndrome in bits 7:0} of the latest faulty word. For one error at bit p this is {1,p}; for two errors at p and q it is {0,p^q}.
- R8: Register address 2 bit 0 is a sticky fatal flag. It is set one edge after an `out_fatal` pulse, and `irq` follows it.
- R9: A write with `reg_wbit`=1 clears the addressed register (addresses 0, 1, 2). A write with `reg_wbit`=0 has no effect. Address 3 reads zero.
- R10: If a clear and an event reach a register on the same edge, the event wins: the count becomes 1, the syndrome takes the new value, and the sticky flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_data | input | 128 | Producer data word |
| prod_code | output | 137 | Coded word from the encoder (combinational) |
| cons_valid | input | 1 | Consumer word present |
| cons_code | input | 137 | Coded word arriving at the consumer |
| out_valid | output | 1 | Repaired data usable |
| out_data | output | 128 | Repaired data |
| out_fix | output | 1 | A single error was repaired |
| out_fatal | output | 1 | Uncorrectable word refused |
| irq | output | 1 | Interrupt, equals the sticky fatal flag |
| reg_addr | input | 2 | Register select for read and clear |
| reg_we | input | 1 | Clear strobe |
| reg_wbit | input | 1 | Clear only when 1 |
| reg_rd_data | output | 16 | Selected register value |

## Verification
A wrong syndrome decode shows on the very next cycle: `out_data` differs from the sent data, or a flag is wrong. The bench flips bits at the edges (bit 0, check bits, bit 136) as well as at random positions. Faults in the register stage show one cycle later, as a count, syndrome or sticky value that differs from the bench's running model. This is checked after every word, in the saturation run, and in the cycles where a clear meets an event.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
    localparam int DATA_W = 128;
    localparam int CHK_W  = 8;
    localparam int HAM_N  = DATA_W + CHK_W;
    localparam int CODE_W = HAM_N + 1;
    localparam int SYN_W  = CHK_W + 1;

    typedef struct packed {
        logic              valid;
        logic              fix;
        logic              fatal;
        logic [DATA_W-1:0] data;
        logic [SYN_W-1:0]  syn;
    } chk_state_t;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [CODE_W-1:0] ham_encode(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        logic par;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= HAM_N; p++) begin
            if (!is_pow2(p)) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int j = 0; j < CHK_W; j++) begin
            par = 1'b0;
            for (int p = 1; p <= HAM_N; p++) begin
                if ((((p >> j) & 1) == 1) && !is_pow2(p)) par ^= c[p];
            end
            c[1 << j] = par;
        end
        c[0] = ^c[CODE_W-1:1];
        return c;
    endfunction

    function automatic logic [CHK_W-1:0] ham_syndrome(input logic [CODE_W-1:0] c);
        logic [CHK_W-1:0] s;
        s = '0;
        for (int j = 0; j < CHK_W; j++) begin
            for (int p = 1; p <= HAM_N; p++) begin
                if (((p >> j) & 1) == 1) s[j] ^= c[p];
            end
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] ham_extract(input logic [CODE_W-1:0] c);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= HAM_N; p++) begin
            if (!is_pow2(p)) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/sdg_encoder.sv
module sdg_encoder
    import sdg_pkg::*;
(
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out
);
    always_comb begin
        code_out = ham_encode(data_in);
    end
endmodule

// File: rtl/sdg_checker.sv
module sdg_checker
    import sdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_fix,
    output logic              out_fatal,
    output logic [SYN_W-1:0]  out_syn
);
    chk_state_t st_d, st_q;

    logic [CHK_W-1:0]  syn_c;
    logic              par_c;
    logic [CODE_W-1:0] fixed_c;
    logic              fix_c;
    logic              fatal_c;

    always_comb begin
        syn_c   = ham_syndrome(in_code);
        par_c   = ^in_code;
        fixed_c = in_code;
        fix_c   = 1'b0;
        fatal_c = 1'b0;
        if (par_c) begin
            if (syn_c <= CHK_W'(HAM_N)) begin
                fixed_c[syn_c] = ~in_code[syn_c];
                fix_c = 1'b1;
            end else begin
                fatal_c = 1'b1;
            end
        end else if (syn_c != '0) begin
            fatal_c = 1'b1;
        end

        st_d = st_q;
        if (in_valid) begin
            st_d.valid = ~fatal_c;
            st_d.fix   = fix_c;
            st_d.fatal = fatal_c;
            st_d.data  = ham_extract(fixed_c);
            st_d.syn   = {par_c, syn_c};
        end else begin
            st_d.valid = 1'b0;
            st_d.fix   = 1'b0;
            st_d.fatal = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_fix   = st_q.fix;
    assign out_fatal = st_q.fatal;
    assign out_syn   = st_q.syn;

    // R5: an idle input cycle yields a quiet output cycle
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_valid || out_fix || out_fatal));

    // R2: every accepted word produces either usable data or a refusal
    p_word_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid || out_fatal));
endmodule

// File: rtl/sdg_csr.sv
module sdg_csr
    import sdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_fix,
    input  logic             evt_fatal,
    input  logic [SYN_W-1:0] evt_syn,
    input  logic [1:0]       addr,
    input  logic             we,
    input  logic             wbit,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [SYN_W-1:0] syn;
        logic             sticky;
    } csr_state_t;

    csr_state_t st_d, st_q;
    logic clr_cnt, clr_syn, clr_stk;

    always_comb begin
        clr_cnt = we && wbit && (addr == 2'd0);
        clr_syn = we && wbit && (addr == 2'd1);
        clr_stk = we && wbit && (addr == 2'd2);

        st_d = st_q;
        if (clr_cnt) st_d.count = '0;
        if (evt_fix && (st_d.count != CNT_MAX)) st_d.count = st_d.count + 1'b1;
        if (clr_syn) st_d.syn = '0;
        if (evt_fix || evt_fatal) st_d.syn = evt_syn;
        if (clr_stk) st_d.sticky = 1'b0;
        if (evt_fatal) st_d.sticky = 1'b1;

        rd_data = '0;
        case (addr)
            2'd0:    rd_data = st_q.count;
            2'd1:    rd_data[SYN_W-1:0] = st_q.syn;
            2'd2:    rd_data[0] = st_q.sticky;
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.sticky;

    // R6: the count never drops without a clear
    p_count_no_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cnt |=> st_q.count >= $past(st_q.count));

    // R6: the count holds at its ceiling
    p_count_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == CNT_MAX && !clr_cnt) |=> st_q.count == CNT_MAX);

    // R8: a fatal event always leaves the sticky flag set
    p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_fatal |=> st_q.sticky);

    // R8: the sticky flag only falls through a clear
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sticky && !clr_stk) |=> st_q.sticky);
endmodule

// File: rtl/sdg_stream_guard.sv
module sdg_stream_guard
    import sdg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] prod_data,
    output logic [CODE_W-1:0] prod_code,
    input  logic              cons_valid,
    input  logic [CODE_W-1:0] cons_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_fix,
    output logic              out_fatal,
    output logic              irq,
    input  logic [1:0]        reg_addr,
    input  logic              reg_we,
    input  logic              reg_wbit,
    output logic [CNT_W-1:0]  reg_rd_data
);
    logic [SYN_W-1:0] chk_syn;

    sdg_encoder u_enc (
        .data_in  (prod_data),
        .code_out (prod_code)
    );

    sdg_checker u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (cons_valid),
        .in_code   (cons_code),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_fix   (out_fix),
        .out_fatal (out_fatal),
        .out_syn   (chk_syn)
    );

    sdg_csr #(.CNT_W(CNT_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_fix   (out_fix),
        .evt_fatal (out_fatal),
        .evt_syn   (chk_syn),
        .addr      (reg_addr),
        .we        (reg_we),
        .wbit      (reg_wbit),
        .rd_data   (reg_rd_data),
        .irq       (irq)
    );
endmodule

// File: tb/sdg_stream_guard_test.sv
module sdg_stream_guard_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic [127:0] prod_data;
    logic [136:0] prod_code;
    logic         cons_valid;
    logic [136:0] cons_code;
    logic         out_valid;
    logic [127:0] out_data;
    logic         out_fix;
    logic         out_fatal;
    logic         irq;
    logic [1:0]   reg_addr;
    logic         reg_we;
    logic         reg_wbit;
    logic [15:0]  reg_rd_data;

    sdg_stream_guard uut (
        .clk(clk), .rst_n(rst_n), .prod_data(prod_data), .prod_code(prod_code),
        .cons_valid(cons_valid), .cons_code(cons_code), .out_valid(out_valid),
        .out_data(out_data), .out_fix(out_fix), .out_fatal(out_fatal), .irq(irq),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wbit(reg_wbit),
        .reg_rd_data(reg_rd_data)
    );

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    logic [8:0] exp_syn = '0;
    logic exp_stk = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [136:0] act, input logic [136:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit pw2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Coded layout per R1
    function automatic logic [136:0] tb_encode(input logic [127:0] d);
        logic [136:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= 136; p++) if (!pw2(p)) begin c[p] = d[k]; k++; end
        for (int j = 0; j < 8; j++) begin
            for (int p = 3; p <= 136; p++)
                if (!pw2(p) && ((p >> j) & 1) == 1) c[1 << j] = c[1 << j] ^ c[p];
        end
        c[0] = ^c[136:1];
        return c;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic read_reg(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rd_data;
    endtask

    task automatic check_regs(input string req);
        logic [15:0] v;
        read_reg(2'd0, v);
        check(v == exp_cnt[15:0], req, "count", 137'(v), 137'(exp_cnt[15:0]));
        read_reg(2'd1, v);
        check(v == {7'b0, exp_syn}, req, "syndrome", 137'(v), 137'(exp_syn));
        read_reg(2'd2, v);
        check(v == {15'b0, exp_stk}, req, "sticky", 137'(v), 137'(exp_stk));
        check(irq == exp_stk, "R8", "irq", 137'(irq), 137'(exp_stk));
    endtask

    task automatic clear_reg(input logic [1:0] a, input logic b);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wbit = b;
        @(negedge clk);
        reg_we = 1'b0; reg_wbit = 1'b0;
    endtask

    // kind 0 clean, 1 single flip at p, 2 double flip at p and q
    task automatic run_case(input logic [127:0] d, input int kind, input int p, input int q);
        logic [136:0] c;
        c = tb_encode(d);
        if (kind >= 1) c[p] = ~c[p];
        if (kind == 2) c[q] = ~c[q];
        @(negedge clk);
        cons_valid = 1'b1; cons_code = c;
        @(negedge clk);
        cons_valid = 1'b0;
        if (kind == 0) begin
            check(out_valid && !out_fix && !out_fatal, "R2", "flags clean",
                  137'({out_valid, out_fix, out_fatal}), 137'(3'b100));
            check(out_data == d, "R2", "data clean", 137'(out_data), 137'(d));
        end else if (kind == 1) begin
            check(out_valid && out_fix && !out_fatal, "R3", "flags single",
                  137'({out_valid, out_fix, out_fatal}), 137'(3'b110));
            check(out_data == d, "R3", "data repaired", 137'(out_data), 137'(d));
            if (exp_cnt < 65535) exp_cnt++;
            exp_syn = {1'b1, 8'(p)};
        end else begin
            check(!out_valid && !out_fix && out_fatal, "R4", "flags double",
                  137'({out_valid, out_fix, out_fatal}), 137'(3'b001));
            exp_syn = {1'b0, 8'(p ^ q)};
            exp_stk = 1'b1;
        end
        @(negedge clk);
        check_regs(kind == 1 ? "R6" : (kind == 2 ? "R7" : "R2"));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [136:0] c;
        logic [15:0] v;
        void'($urandom(32'd4242));
        rst_n = 1'b0; cons_valid = 1'b0; cons_code = '0; prod_data = '0;
        reg_addr = 2'd0; reg_we = 1'b0; reg_wbit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        check(!out_valid && !out_fix && !out_fatal, "R5", "reset outputs",
              137'({out_valid, out_fix, out_fatal}), 137'(0));
        check_regs("R5");
        read_reg(2'd3, v);
        check(v == 16'd0, "R9", "address 3", 137'(v), 137'(0));

        // R1 encoder layout
        for (int i = 0; i < 20; i++) begin
            prod_data = (i == 0) ? '0 : (i == 1) ? '1 : rnd128();
            #1;
            check(prod_code == tb_encode(prod_data), "R1", "coded word",
                  prod_code, tb_encode(prod_data));
            check(^prod_code == 1'b0, "R1", "even parity", 137'(^prod_code), 137'(0));
        end

        // Directed corners
        run_case('0, 0, 0, 0);
        run_case('1, 0, 0, 0);
        run_case(rnd128(), 1, 0, 0);
        run_case(rnd128(), 1, 136, 0);
        run_case(rnd128(), 1, 1, 0);
        run_case(rnd128(), 1, 128, 0);
        run_case('1, 1, 3, 0);
        run_case(rnd128(), 2, 0, 136);
        run_case(rnd128(), 2, 1, 2);
        run_case(rnd128(), 2, 0, 5);

        // R5 idle with corrupted code leaves everything untouched
        @(negedge clk);
        cons_valid = 1'b0;
        cons_code = tb_encode(rnd128()) ^ 137'h3;
        @(negedge clk);
        check(!out_valid && !out_fix && !out_fatal, "R5", "idle outputs",
              137'({out_valid, out_fix, out_fatal}), 137'(0));
        @(negedge clk);
        check_regs("R5");

        // R9 write with bit 0 is ignored; write one clears
        clear_reg(2'd0, 1'b0);
        clear_reg(2'd2, 1'b0);
        check_regs("R9");
        clear_reg(2'd0, 1'b1); exp_cnt = 0;
        clear_reg(2'd1, 1'b1); exp_syn = '0;
        clear_reg(2'd2, 1'b1); exp_stk = 1'b0;
        check_regs("R9");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int kind, p, q;
            kind = int'($urandom_range(0, 2));
            p = int'($urandom_range(0, 136));
            q = int'($urandom_range(0, 136));
            if (q == p) q = (p + 1) % 137;
            run_case(rnd128(), kind, p, q);
        end

        // R10 clear meets event on the same edge
        clear_reg(2'd0, 1'b1); exp_cnt = 0;
        clear_reg(2'd2, 1'b1); exp_stk = 1'b0;
        c = tb_encode(rnd128()); c[7] = ~c[7];
        @(negedge clk);
        cons_valid = 1'b1; cons_code = c;
        @(negedge clk);
        cons_valid = 1'b0; reg_we = 1'b1; reg_addr = 2'd0; reg_wbit = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        read_reg(2'd0, v);
        check(v == 16'd1, "R10", "count clear vs fix", 137'(v), 137'(1));
        c = tb_encode(rnd128()); c[9] = ~c[9]; c[20] = ~c[20];
        @(negedge clk);
        cons_valid = 1'b1; cons_code = c;
        @(negedge clk);
        cons_valid = 1'b0; reg_we = 1'b1; reg_addr = 2'd2; reg_wbit = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        read_reg(2'd2, v);
        check(v == 16'd1, "R10", "sticky clear vs fatal", 137'(v), 137'(1));
        c = tb_encode(rnd128()); c[33] = ~c[33];
        @(negedge clk);
        cons_valid = 1'b1; cons_code = c;
        @(negedge clk);
        cons_valid = 1'b0; reg_we = 1'b1; reg_addr = 2'd1; reg_wbit = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        read_reg(2'd1, v);
        check(v == {7'b0, 1'b1, 8'd33}, "R10", "syndrome clear vs fix", 137'(v), 137'(9'h121));

        // R6 saturation
        clear_reg(2'd0, 1'b1);
        c = tb_encode(rnd128()); c[50] = ~c[50];
        @(negedge clk);
        cons_valid = 1'b1; cons_code = c;
        repeat (65540) @(negedge clk);
        cons_valid = 1'b0;
        repeat (2) @(negedge clk);
        read_reg(2'd0, v);
        check(v == 16'hFFFF, "R6", "saturated count", 137'(v), 137'(16'hFFFF));
        read_reg(2'd1, v);
        check(v == {7'b0, 1'b1, 8'd50}, "R7", "syndrome after run", 137'(v), 137'(9'h132));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule